// File: doc/BRIEF.md
# Sixteen-Pin GPIO Expander Core

This block is the register and interrupt core of a general-purpose I/O expander. A serial bus front end, which is not part of this block, turns bus transactions into single-byte register writes and reads on a flat 8-bit address port. The core keeps the per-pin configuration: direction, output latch, pull-up and pull-down enables, open-drain enable, input polarity, interrupt mask and a 2-bit edge-sense field. It passes the pin inputs through a synchronizer and drives the output enables and output levels.

Selected rising or falling edges on input pins set bits in an event source register. Software clears these bits by writing ones to them. An active-low summary interrupt stays asserted while any source bit whose pin is unmasked is set. A soft reset restores every register to its power-up value. It takes effect only after a two-byte unlock sequence written to a dedicated address.

Configuration bytes are laid out in descending order. The byte for the lowest pins sits at the highest address of each group, and higher pins move to lower addresses.

Top module: `gpx_expander_core`

## Requirements
- R1: After reset the direction register reads 0xFF at 0x0F and 0x0E, so every pin is an input and `pin_oe` is all zero. The output latch holds all ones. The mask reads 0xFF at 0x13 and 0x12. The pull, open-drain, polarity, sense, source and miscellaneous registers are zero, and `irq_n` is 1.
- R2: Each one-bit-per-pin register holds pins 0–7 at its base address N and pins 8–15 at N−1, with pin k at bit k mod 8. The bases are: direction 0x0F, mask 0x13, output data 0x11, pull-up 0x07, polarity 0x0D, pull-down 0x09, open-drain 0x0B. Every bit written reads back unchanged, except the output data register (see R4).
- R3: A direction bit of 0 makes the pin an output: its `pin_oe` bit is 1 and `pin_out` carries the latch bit. A direction bit of 1 sets `pin_oe` to 0. Writes to the data register update the latch for every pin, whatever its direction.
- R4: Reading the data register returns the latch bit for output pins. For input pins it returns the synchronized pin level XOR the polarity bit. A pin change is visible from the second rising clock edge after it.
- R5: Sense fields are 2 bits per pin, four pins per byte. Pins 0–3 are at 0x17, pins 4–7 at 0x16, pins 8–11 at 0x15 and pins 12–15 at 0x14, with pin k at bit offset 2k mod 8. Field bit 0 enables rising-edge detection, bit 1 enables falling-edge detection, both bits enable both edges, and 00 disables detection.
- R6: A selected edge of the polarity-adjusted level sets that pin's source bit on the third rising edge after the pin change. The source bit is set whether or not the pin is masked. Source bits for pins 0–7 are at 0x19 and for pins 8–15 at 0x18.
- R7: Writing 1 to a source bit clears it, and writing 0 leaves it as it was. An event arriving on the same edge as a clearing write leaves the bit set.
- R8: `irq_n` is 0 exactly while some source bit is set whose mask bit is 0. Mask bit 1 blocks the pin.
- R9: Two consecutive writes to 0x7D, first 0x12 and then 0x34, restore all R1 values on the second write. Any other write between them aborts the sequence.
- R10: The miscellaneous register at 0x1F is a plain 8-bit read/write register. Unmapped addresses and 0x7D read as 0x00, and writes to them change no register.
- R11: `pull_up_en`, `pull_dn_en` and `open_drain_en` carry the pull-up, pull-down and open-drain registers bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one register byte |
| addr | input | 8 | Register address for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pin_in | input | NPINS (16) | Raw pin input levels |
| pin_out | output | NPINS (16) | Output latch values |
| pin_oe | output | NPINS (16) | Per-pin output enable |
| pull_up_en | output | NPINS (16) | Pull-up enables |
| pull_dn_en | output | NPINS (16) | Pull-down enables |
| open_drain_en | output | NPINS (16) | Open-drain enables |
| irq_n | output | 1 | Active-low summary interrupt |

## Verification
The bench goes after the descending byte order. A design that swaps the bytes of a group puts pin 13's sense or source bit at the wrong address, and its readback or `irq_n` check fails. Single-edge sense fields are driven against both pin directions, so a design that ignores the field bits, or swaps rising and falling, latches an event that must stay clear. An event is made to arrive on the same edge as the write that clears it; a clear-wins design loses the event. The unlock sequence is interrupted by a write to another register, and a design that only compares the two values in isolation resets when it must not.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   // indexes of the one-bit-per-pin configuration banks
   localparam int IDX_PULLUP = 0;
   localparam int IDX_PULLDN = 1;
   localparam int IDX_OPENDR = 2;
   localparam int IDX_POLAR  = 3;
   localparam int IDX_DIR    = 4;
   localparam int IDX_DATA   = 5;
   localparam int IDX_MASK   = 6;
   localparam int NUM_CFG    = 7;

   // power-up fill byte of each bank: inputs, latch high, all masked
   function automatic logic [7:0] cfg_reset(int idx);
      return (idx == IDX_DIR || idx == IDX_DATA || idx == IDX_MASK) ? 8'hFF : 8'h00;
   endfunction

   // byte j of a descending group starts at base and moves downward
   function automatic logic [7:0] byte_addr(logic [7:0] base, int j);
      return base - 8'(j);
   endfunction

endpackage

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpx_pin_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else if (s == 0) stg[s] <= d;
         else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpx_edge_det.sv
module gpx_edge_det #(
   parameter int NPINS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPINS-1:0]   lvl,
   input  logic [2*NPINS-1:0] sense,
   output logic [NPINS-1:0]   evt
);

   logic [NPINS-1:0] prev_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= '0;
      else prev_lvl <= lvl;
   end

   for (genvar k = 0; k < NPINS; k++) begin : g_pin
      logic rise, fall;
      assign rise   = lvl[k] & ~prev_lvl[k];
      assign fall   = ~lvl[k] & prev_lvl[k];
      assign evt[k] = (sense[2*k] & rise) | (sense[2*k+1] & fall);
   end

   // an event can only come from a pin whose level just moved
   AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt & ~(lvl ^ prev_lvl)) == '0); // R6

   // with every sense field at 00 nothing is detected
   AST_SENSE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == '0) |-> (evt == '0)); // R5

endmodule

// File: rtl/gpx_cfg_bank.sv
module gpx_cfg_bank #(
   parameter int         NBYTES   = 2,
   parameter logic [7:0] BASE     = 8'h0F,
   parameter logic [7:0] RST_BYTE = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  srst,
   input  logic                  wr_en,
   input  logic [7:0]            addr,
   input  logic [7:0]            wr_data,
   output logic [8*NBYTES-1:0]   q
);

   if (int'(BASE) < NBYTES - 1) begin : g_bad_base
      $error("gpx_cfg_bank base address too low for its byte count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {NBYTES{RST_BYTE}};
      else if (srst) q <= {NBYTES{RST_BYTE}};
      else if (wr_en) begin
         for (int j = 0; j < NBYTES; j++) begin
            if (addr == gpx_pkg::byte_addr(BASE, j)) q[8*j +: 8] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/gpx_irq_src.sv
module gpx_irq_src #(
   parameter int         NPINS = 16,
   parameter logic [7:0] BASE  = 8'h19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic [NPINS-1:0] evt,
   input  logic             wr_en,
   input  logic [7:0]       addr,
   input  logic [7:0]       wr_data,
   output logic [NPINS-1:0] src
);

   localparam int NB = NPINS / 8;

   logic [NPINS-1:0] clr;

   always_comb begin
      clr = '0;
      if (wr_en) begin
         for (int j = 0; j < NB; j++) begin
            if (addr == gpx_pkg::byte_addr(BASE, j)) clr[8*j +: 8] = wr_data;
         end
      end
   end

   // a new event wins over a clearing write on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src <= '0;
      else if (srst) src <= '0;
      else src <= (src & ~clr) | evt;
   end

   AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && evt != '0) |=> ((src & $past(evt)) == $past(evt))); // R6

   AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !wr_en && evt == '0) |=> (src == $past(src))); // R7

   AST_SRC_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == '0) |=> ((src & ~$past(src)) == '0)); // R7

endmodule

// File: rtl/gpx_soft_rst.sv
module gpx_soft_rst #(
   parameter logic [7:0] RST_ADDR = 8'h7D,
   parameter logic [7:0] KEY_A    = 8'h12,
   parameter logic [7:0] KEY_B    = 8'h34
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] addr,
   input  logic [7:0] wr_data,
   output logic       srst
);

   logic armed;
   logic hit_a;

   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("gpx_soft_rst unlock keys must differ");
   end

   assign hit_a = (addr == RST_ADDR) && (wr_data == KEY_A);

   // every write re-evaluates the armed state: only the first key arms
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else if (wr_en) armed <= hit_a;
   end

   assign srst = wr_en && armed && (addr == RST_ADDR) && (wr_data == KEY_B);

   AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !srst); // R9

   AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit_a) |=> !srst); // R9

endmodule

// File: rtl/gpx_expander_core.sv
module gpx_expander_core #(
   parameter int         NPINS       = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] CFG_BASE [gpx_pkg::NUM_CFG] =
      '{8'h07, 8'h09, 8'h0B, 8'h0D, 8'h0F, 8'h11, 8'h13},
   parameter logic [7:0] SENSE_BASE  = 8'h17,
   parameter logic [7:0] SRC_BASE    = 8'h19,
   parameter logic [7:0] MISC_ADDR   = 8'h1F,
   parameter logic [7:0] RST_ADDR    = 8'h7D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       addr,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pull_up_en,
   output logic [NPINS-1:0] pull_dn_en,
   output logic [NPINS-1:0] open_drain_en,
   output logic             irq_n
);

   import gpx_pkg::*;

   localparam int NB  = NPINS / 8;
   localparam int NB2 = NPINS / 4;

   if (NPINS % 8 != 0 || NPINS < 8 || NPINS > 32) begin : g_bad_npins
      $error("gpx_expander_core NPINS must be 8, 16, 24 or 32");
   end

   logic [NPINS-1:0]   cfg [NUM_CFG];
   logic [2*NPINS-1:0] sense;
   logic [7:0]         misc;
   logic [NPINS-1:0]   sync_in, lvl, evt, src, data_view;
   logic               srst;

   gpx_soft_rst #(.RST_ADDR(RST_ADDR)) u_unlock (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .srst(srst));

   for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
      gpx_cfg_bank #(.NBYTES(NB), .BASE(CFG_BASE[k]), .RST_BYTE(cfg_reset(k))) u_bank (
         .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .addr(addr),
         .wr_data(wr_data), .q(cfg[k]));
   end

   gpx_cfg_bank #(.NBYTES(NB2), .BASE(SENSE_BASE), .RST_BYTE(8'h00)) u_sense (
      .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .q(sense));

   gpx_cfg_bank #(.NBYTES(1), .BASE(MISC_ADDR), .RST_BYTE(8'h00)) u_misc (
      .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .q(misc));

   gpx_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in));

   assign lvl = sync_in ^ cfg[IDX_POLAR];

   gpx_edge_det #(.NPINS(NPINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .sense(sense), .evt(evt));

   gpx_irq_src #(.NPINS(NPINS), .BASE(SRC_BASE)) u_src (
      .clk(clk), .rst_n(rst_n), .srst(srst), .evt(evt), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .src(src));

   assign data_view     = (cfg[IDX_DIR] & lvl) | (~cfg[IDX_DIR] & cfg[IDX_DATA]);
   assign pin_out       = cfg[IDX_DATA];
   assign pin_oe        = ~cfg[IDX_DIR];
   assign pull_up_en    = cfg[IDX_PULLUP];
   assign pull_dn_en    = cfg[IDX_PULLDN];
   assign open_drain_en = cfg[IDX_OPENDR];
   assign irq_n         = ~|(src & ~cfg[IDX_MASK]);

   always_comb begin
      rd_data = 8'h00;
      for (int k = 0; k < NUM_CFG; k++) begin
         for (int j = 0; j < NB; j++) begin
            if (addr == byte_addr(CFG_BASE[k], j))
               rd_data = (k == IDX_DATA) ? data_view[8*j +: 8] : cfg[k][8*j +: 8];
         end
      end
      for (int j = 0; j < NB2; j++) begin
         if (addr == byte_addr(SENSE_BASE, j)) rd_data = sense[8*j +: 8];
      end
      for (int j = 0; j < NB; j++) begin
         if (addr == byte_addr(SRC_BASE, j)) rd_data = src[8*j +: 8];
      end
      if (addr == MISC_ADDR) rd_data = misc;
   end

   AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[IDX_MASK] == '1) |-> irq_n); // R8

   AST_SRST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (src == '0 && cfg[IDX_MASK] == '1 && cfg[IDX_DIR] == '1 && sense == '0)); // R9

endmodule

// File: tb/test_gpx_expander_core.sv
module test_gpx_expander_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic [15:0] pin_in = 16'h0000;
   logic [15:0] pin_out, pin_oe, pull_up_en, pull_dn_en, open_drain_en;
   logic        irq_n;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   gpx_expander_core i_gpx_expander_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
      .open_drain_en(open_drain_en), .irq_n(irq_n));

   // {address, write byte, expected readback}
   localparam logic [23:0] VEC [17] = '{
      24'h078181, 24'h064242, 24'h091818, 24'h082424, 24'h0B0F0F, 24'h0AF0F0,
      24'h0DA5A5, 24'h0C3C3C, 24'h0D0000, 24'h0C0000, 24'h1FC3C3, 24'h15E4E4,
      24'h150000, 24'h205500, 24'h7D0000, 24'h057700, 24'h1A9900};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, {24'h0, d}, {24'h0, exp});
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1 reset state
      rd_chk("R1 dir low", 8'h0F, 8'hFF);
      rd_chk("R1 dir high", 8'h0E, 8'hFF);
      rd_chk("R1 mask", 8'h13, 8'hFF);
      rd_chk("R1 sense", 8'h17, 8'h00);
      rd_chk("R1 source", 8'h19, 8'h00);
      chk("R1 pin_out", pin_out, 16'hFFFF);
      chk("R1 pin_oe", pin_oe, 16'h0000);
      chk("R1 irq_n", irq_n, 1'b1);

      // R2 R10 register readback table
      for (int i = 0; i < 17; i++) begin
         wr(VEC[i][23:16], VEC[i][15:8]);
         rd_chk("R2 R10 table", VEC[i][23:16], VEC[i][7:0]);
      end
      chk("R11 pull-up", pull_up_en, 16'h4281);
      chk("R11 pull-down", pull_dn_en, 16'h2418);
      chk("R11 open-drain", open_drain_en, 16'hF00F);

      // R3 R4 direction, latch and readback
      wr(8'h0F, 8'hF0);
      wr(8'h0E, 8'h0F);
      wr(8'h11, 8'hF5);
      wr(8'h10, 8'h30);
      chk("R3 pin_oe", pin_oe, 16'hF00F);
      chk("R3 latch ignores direction", pin_out, 16'h30F5);
      pin_in = 16'h0A50;
      settle();
      rd_chk("R4 data low", 8'h11, 8'h55);
      rd_chk("R4 data high", 8'h10, 8'h3A);
      wr(8'h0D, 8'hF0);
      rd_chk("R4 polarity", 8'h11, 8'hA5);
      wr(8'h0D, 8'h00);
      wr(8'h0F, 8'hFF);
      wr(8'h0E, 8'hFF);
      pin_in = 16'h0000;
      settle();

      // R5 sense packing: pin5 rising, pin13 falling, pin0 both
      wr(8'h16, 8'h04);
      wr(8'h14, 8'h08);
      wr(8'h17, 8'h03);
      rd_chk("R5 no event from config", 8'h19, 8'h00);

      // R6 R8 masked pin still latches
      pin_in[5] = 1'b1;
      settle();
      rd_chk("R6 pin5 rise", 8'h19, 8'h20);
      chk("R8 masked quiet", irq_n, 1'b1);
      wr(8'h13, 8'hDF);
      chk("R8 unmasked asserts", irq_n, 1'b0);
      pin_in[5] = 1'b0;
      settle();
      rd_chk("R5 falling ignored on rising-only", 8'h19, 8'h20);

      // R7 write-one-to-clear
      wr(8'h19, 8'h00);
      rd_chk("R7 zero write keeps", 8'h19, 8'h20);
      wr(8'h19, 8'h20);
      rd_chk("R7 one write clears", 8'h19, 8'h00);
      chk("R8 released", irq_n, 1'b1);

      // R5 R6 pin13 falling only, upper byte
      pin_in[13] = 1'b1;
      settle();
      rd_chk("R5 rising ignored on falling-only", 8'h18, 8'h00);
      pin_in[13] = 1'b0;
      settle();
      rd_chk("R6 pin13 fall", 8'h18, 8'h20);
      chk("R8 pin13 masked", irq_n, 1'b1);
      wr(8'h12, 8'hDF);
      chk("R8 pin13 unmasked", irq_n, 1'b0);
      wr(8'h18, 8'h20);
      chk("R7 R8 cleared high", irq_n, 1'b1);

      // R5 both edges on pin0
      pin_in[0] = 1'b1;
      settle();
      rd_chk("R5 both rise", 8'h19, 8'h01);
      wr(8'h19, 8'h01);
      pin_in[0] = 1'b0;
      settle();
      rd_chk("R5 both fall", 8'h19, 8'h01);
      wr(8'h19, 8'h01);
      rd_chk("R7 cleared pin0", 8'h19, 8'h00);

      // R7 event on the same edge as the clear
      pin_in[0] = 1'b1;
      @(negedge clk);
      wr(8'h19, 8'h01);
      rd_chk("R7 set wins", 8'h19, 8'h01);

      // R9 aborted unlock sequences
      wr(8'h7D, 8'h12);
      wr(8'h1F, 8'h3C);
      wr(8'h7D, 8'h34);
      rd_chk("R9 abort keeps mask", 8'h13, 8'hDF);
      rd_chk("R9 abort keeps misc", 8'h1F, 8'h3C);
      wr(8'h7D, 8'h12);
      wr(8'h7D, 8'h55);
      wr(8'h7D, 8'h34);
      rd_chk("R9 wrong key keeps mask", 8'h12, 8'hDF);

      // R9 full unlock
      wr(8'h7D, 8'h12);
      wr(8'h7D, 8'h34);
      rd_chk("R9 mask restored", 8'h13, 8'hFF);
      rd_chk("R9 source cleared", 8'h19, 8'h00);
      rd_chk("R9 misc cleared", 8'h1F, 8'h00);
      rd_chk("R9 sense cleared", 8'h16, 8'h00);
      chk("R9 pull-up cleared", pull_up_en, 16'h0000);
      chk("R9 irq_n", irq_n, 1'b1);
      chk("R9 latch high", pin_out, 16'hFFFF);

      finish_run();
   end

endmodule